// File: doc/BRIEF.md
# Serial Controller Interrupt Identification and Routing Unit

This block is the interrupt section of a 16550-style serial controller. Four event inputs stand in for the serial datapath: a line-status event, received data ready, a receive timeout and transmitter holding register empty. Four modem-status input lines act as external interrupt sources. Each event sets a pending flag that stays set until a host access clears it. The host accesses the block through a small register window with an address, write data, a read strobe and a write strobe. Read data is combinational from the address.

An enable register selects which pending sources may interrupt. A fixed priority encoder picks the most urgent enabled source and reports it in the identification register. The combined pending condition goes to two active-low outputs, a maskable interrupt and a non-maskable interrupt. Two modem-control bits gate each output separately, so software can pick either output, both or neither. The modem-status lines keep change flags. Three of them flag any change, and one flags only a high-to-low transition, so releasing that source never raises a second interrupt.

Reads of the receive buffer (offset 0) and of line status (offset 5) return zero here, because their data comes from the datapath outside this unit. Those reads still clear interrupts.

Top module: `uart_irq_unit`

## Requirements
- R1: The enable register at offset 1 holds four bits: bit 0 received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status. It reads back with bits 7..4 as zero. A pending source whose enable bit is 0 is not reported and does not interrupt.
- R2: The identification register at offset 2 reads bit 0 = 1 when no enabled source is pending and bit 0 = 0 when one is pending. Bits 3..1 carry the source code and bits 7..4 are zero. After reset it reads 0x01.
- R3: Source codes in bits 3..1 are 3 for line status, 2 for received data, 6 for receive timeout, 1 for transmit empty and 0 for modem status.
- R4: Among enabled pending sources, the one reported is chosen in this order: line status, then received data, then timeout, then transmit empty, then modem status.
- R5: A read at offset 5 clears the line-status flag. A read at offset 0 clears both the received-data flag and the timeout flag.
- R6: The transmit-empty flag clears on a write at offset 0. It also clears on a read of offset 2 while transmit empty is the source reported. A read of offset 2 that reports another source leaves it set.
- R7: A read at offset 6 returns the registered line levels in bits 7..4 and the change flags in bits 3..1..0. The read clears all change flags. The modem-status source is pending while any change flag is set.
- R8: Change flags 0, 1 and 3 set on any change of their line. Change flag 2 sets only when its line goes from 1 to 0.
- R9: The interrupt output is low exactly when, one clock earlier, a source was reported and modem-control bit 2 was 0. The non-maskable output follows the same rule with modem-control bit 3. Both outputs are high after reset.
- R10: The modem-control register at offset 4 stores bits 4..0 and reads them back with bits 7..5 as zero. Bits 0, 1 and 4 do not affect either output.
- R11: The scratch register at offset 7 reads back the last value written to it and has no effect on any other register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe; side effects occur at the clock edge |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data for the addressed register |
| ls_evt_i | input | 1 | Line-status event pulse |
| rx_avail_i | input | 1 | Received-data-ready pulse |
| rx_tmo_i | input | 1 | Receive-timeout pulse |
| tx_empty_i | input | 1 | Transmit-holding-empty pulse |
| ms_lines_i | input | MS_W | Modem-status lines used as external sources |
| int_n_o | output | 1 | Maskable interrupt, active low |
| nmi_n_o | output | 1 | Non-maskable interrupt, active low |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, four modem-status lines and only line 2 set to trailing-edge detection. With these values every source code and both edge-detection variants can be reached from the ports. The register layout then matches the 8-bit host view, so every field can be read back and checked directly. The directed scenarios stack all five sources at once and peel them off one clearing access at a time. They also walk every routing combination of the two gate bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ADDR_W = 3;
    localparam int IER_W  = 4;
    localparam int MCR_W  = 5;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    localparam int GATE_INT = 2;
    localparam int GATE_NMI = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    typedef enum logic [2:0] {
        SRC_MODEM   = 3'd0,
        SRC_TXEMPTY = 3'd1,
        SRC_RXDATA  = 3'd2,
        SRC_LINE    = 3'd3,
        SRC_TIMEOUT = 3'd6
    } src_code_e;

endpackage

// File: rtl/uart_irq_msr.sv
module uart_irq_msr #(
    parameter int               LINES      = 4,
    parameter logic [LINES-1:0] TRAIL_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic             clr_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] delta_o
);

    typedef struct packed {
        logic             primed;
        logic [LINES-1:0] level;
        logic [LINES-1:0] delta;
    } msr_st_t;

    msr_st_t s_d, s_q;
    logic [LINES-1:0] hit;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_edge
            if (TRAIL_ONLY[g]) begin : g_fall
                assign hit[g] = s_q.primed & s_q.level[g] & ~lines_i[g];
            end else begin : g_any
                assign hit[g] = s_q.primed & (s_q.level[g] ^ lines_i[g]);
            end
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.primed = 1'b1;
        s_d.level  = lines_i;
        s_d.delta  = (clr_i ? '0 : s_q.delta) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.level;
    assign delta_o = s_q.delta;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [IER_W-1:0] en_i,
    input  logic             ls_i,
    input  logic             rd_i,
    input  logic             to_i,
    input  logic             tx_i,
    input  logic             ms_i,
    output logic             none_o,
    output logic [2:0]       code_o
);

    always_comb begin
        none_o = 1'b0;
        code_o = SRC_MODEM;
        if (en_i[EN_LS] && ls_i) begin
            code_o = SRC_LINE;
        end else if (en_i[EN_RX] && rd_i) begin
            code_o = SRC_RXDATA;
        end else if (en_i[EN_RX] && to_i) begin
            code_o = SRC_TIMEOUT;
        end else if (en_i[EN_TX] && tx_i) begin
            code_o = SRC_TXEMPTY;
        end else if (en_i[EN_MS] && ms_i) begin
            code_o = SRC_MODEM;
        end else begin
            none_o = 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic int_block_i,
    input  logic nmi_block_i,
    output logic int_n_o,
    output logic nmi_n_o
);

    typedef struct packed {
        logic int_n;
        logic nmi_n;
    } route_st_t;

    route_st_t s_d, s_q;

    always_comb begin
        s_d.int_n = ~(pend_i & ~int_block_i);
        s_d.nmi_n = ~(pend_i & ~nmi_block_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign int_n_o = s_q.int_n;
    assign nmi_n_o = s_q.nmi_n;

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int            DATA_W   = 8,
    parameter int            MS_W     = 4,
    parameter logic [MS_W-1:0] MS_TRAIL = 4'b0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic                 ls_evt_i,
    input  logic                 rx_avail_i,
    input  logic                 rx_tmo_i,
    input  logic                 tx_empty_i,
    input  logic [MS_W-1:0]      ms_lines_i,
    output logic                 int_n_o,
    output logic                 nmi_n_o
);

    localparam int MSR_BITS = 2 * MS_W;

    typedef struct packed {
        logic [IER_W-1:0]  ier;
        logic [MCR_W-1:0]  mcr;
        logic [DATA_W-1:0] scr;
        logic              ls;
        logic              rd;
        logic              to;
        logic              tx;
    } core_st_t;

    core_st_t s_d, s_q;

    logic [IER_W-1:0]  ier_q;
    logic [MCR_W-1:0]  mcr_q;
    logic [DATA_W-1:0] scr_q;
    logic              ls_pend, rd_pend, to_pend, tx_pend;
    logic              irq_none;
    logic [2:0]        irq_code;
    logic [MS_W-1:0]   ms_level, ms_delta;
    logic              msr_read, lsr_read, data_read, iir_read, data_write;
    logic              tx_shown;

    assign ier_q   = s_q.ier;
    assign mcr_q   = s_q.mcr;
    assign scr_q   = s_q.scr;
    assign ls_pend = s_q.ls;
    assign rd_pend = s_q.rd;
    assign to_pend = s_q.to;
    assign tx_pend = s_q.tx;

    assign msr_read   = rd_i && (addr_i == OFS_MSR);
    assign lsr_read   = rd_i && (addr_i == OFS_LSR);
    assign data_read  = rd_i && (addr_i == OFS_DATA);
    assign iir_read   = rd_i && (addr_i == OFS_IIR);
    assign data_write = wr_i && (addr_i == OFS_DATA);

    uart_irq_msr #(
        .LINES      (MS_W),
        .TRAIL_ONLY (MS_TRAIL)
    ) u_msr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (ms_lines_i),
        .clr_i   (msr_read),
        .level_o (ms_level),
        .delta_o (ms_delta)
    );

    uart_irq_prio u_prio (
        .en_i   (ier_q),
        .ls_i   (ls_pend),
        .rd_i   (rd_pend),
        .to_i   (to_pend),
        .tx_i   (tx_pend),
        .ms_i   (|ms_delta),
        .none_o (irq_none),
        .code_o (irq_code)
    );

    assign tx_shown = !irq_none && (irq_code == SRC_TXEMPTY);

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            case (addr_i)
                OFS_IER: s_d.ier = wdata_i[IER_W-1:0];
                OFS_MCR: s_d.mcr = wdata_i[MCR_W-1:0];
                OFS_SCR: s_d.scr = wdata_i;
                default: ;
            endcase
        end
        s_d.ls = (ls_pend & ~lsr_read) | ls_evt_i;
        s_d.rd = (rd_pend & ~data_read) | rx_avail_i;
        s_d.to = (to_pend & ~data_read) | rx_tmo_i;
        s_d.tx = (tx_pend & ~data_write & ~(iir_read & tx_shown)) | tx_empty_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_IER: rdata_o[IER_W-1:0]    = ier_q;
            OFS_IIR: rdata_o[3:0]          = {irq_code, irq_none};
            OFS_MCR: rdata_o[MCR_W-1:0]    = mcr_q;
            OFS_MSR: rdata_o[MSR_BITS-1:0] = {ms_level, ms_delta};
            OFS_SCR: rdata_o               = scr_q;
            default: rdata_o               = '0;
        endcase
    end

    uart_irq_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (!irq_none),
        .int_block_i (mcr_q[GATE_INT]),
        .nmi_block_i (mcr_q[GATE_NMI]),
        .int_n_o     (int_n_o),
        .nmi_n_o     (nmi_n_o)
    );

endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk #(
    parameter int DATA_W = 8,
    parameter int MS_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic              tx_empty_i,
    input logic [MS_W-1:0]   ms_lines_i,
    input logic              int_n_o,
    input logic              nmi_n_o,
    input logic              irq_none,
    input logic [2:0]        irq_code,
    input logic              ls_pend,
    input logic              tx_pend,
    input logic [3:0]        ier_q,
    input logic [4:0]        mcr_q,
    input logic [DATA_W-1:0] scr_q,
    input logic [MS_W-1:0]   ms_level,
    input logic [MS_W-1:0]   ms_delta
);

    AST_INT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mcr_q[2]) |-> (int_n_o == $past(irq_none))); // R9

    AST_NMI_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mcr_q[3]) |-> (nmi_n_o == $past(irq_none))); // R9

    AST_ROUTE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mcr_q[2] && mcr_q[3]) |-> (int_n_o && nmi_n_o)); // R9

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && ier_q[2]) |-> (!irq_none && irq_code == 3'd3)); // R4

    AST_IDLE_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'd0) |-> irq_none); // R1

    AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == 3'd6 && ms_lines_i == ms_level) |=> (ms_delta == '0)); // R7

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 3'd0 && !tx_empty_i) |=> !tx_pend); // R6

    AST_SCR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == 3'd7) |=> $stable(scr_q)); // R11

    AST_TRAIL_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_delta[2] && (!ms_level[2] || ms_lines_i[2])) |=> !ms_delta[2]); // R8

endmodule

bind uart_irq_unit uart_irq_unit_chk #(
    .DATA_W (DATA_W),
    .MS_W   (MS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .tx_empty_i (tx_empty_i),
    .ms_lines_i (ms_lines_i),
    .int_n_o    (int_n_o),
    .nmi_n_o    (nmi_n_o),
    .irq_none   (irq_none),
    .irq_code   (irq_code),
    .ls_pend    (ls_pend),
    .tx_pend    (tx_pend),
    .ier_q      (ier_q),
    .mcr_q      (mcr_q),
    .scr_q      (scr_q),
    .ms_level   (ms_level),
    .ms_delta   (ms_delta)
);

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       ls_evt = 1'b0;
    logic       rx_avail = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       tx_empty = 1'b0;
    logic [3:0] ms = '0;
    logic       int_n, nmi_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_irq_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rd_i       (rd),
        .wr_i       (wr),
        .rdata_o    (rdata),
        .ls_evt_i   (ls_evt),
        .rx_avail_i (rx_avail),
        .rx_tmo_i   (rx_tmo),
        .tx_empty_i (tx_empty),
        .ms_lines_i (ms),
        .int_n_o    (int_n),
        .nmi_n_o    (nmi_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ls_evt = 1'b1;
            1: rx_avail = 1'b1;
            2: rx_tmo = 1'b1;
            default: tx_empty = 1'b1;
        endcase
        @(negedge clk);
        ls_evt = 1'b0; rx_avail = 1'b0; rx_tmo = 1'b0; tx_empty = 1'b0;
    endtask

    task automatic set_lines(input logic [3:0] v);
        @(negedge clk);
        ms = v;
    endtask

    task automatic t_reset;
        chk("R2 reset identification", {6'd0, int_n, nmi_n}, 8'h03);
        rd_chk("R2 reset identification", 3'd2, 8'h01);
        rd_chk("R1 reset enables", 3'd1, 8'h00);
        rd_chk("R10 reset modem control", 3'd4, 8'h00);
        rd_chk("R7 reset modem status", 3'd6, 8'h00);
    endtask

    task automatic t_scratch;
        reg_wr(3'd7, 8'h5A);
        rd_chk("R11 scratch readback", 3'd7, 8'h5A);
        reg_wr(3'd7, 8'hC3);
        rd_chk("R11 scratch readback", 3'd7, 8'hC3);
        rd_chk("R11 scratch leaves enables", 3'd1, 8'h00);
        rd_chk("R11 scratch leaves identification", 3'd2, 8'h01);
        chk("R11 scratch leaves outputs", {6'd0, int_n, nmi_n}, 8'h03);
    endtask

    task automatic t_enable;
        pulse(3);
        rd_chk("R1 masked source hidden", 3'd2, 8'h01);
        @(negedge clk);
        chk("R1 masked source no interrupt", {6'd0, int_n, nmi_n}, 8'h03);
        reg_wr(3'd1, 8'hFF);
        rd_chk("R1 enable readback width", 3'd1, 8'h0F);
        rd_chk("R3 transmit empty code", 3'd2, 8'h02);
        rd_chk("R6 identification read clears transmit", 3'd2, 8'h01);
    endtask

    task automatic t_tx_clear;
        pulse(3);
        reg_wr(3'd0, 8'h41);
        rd_chk("R6 data write clears transmit", 3'd2, 8'h01);
        pulse(0);
        pulse(3);
        rd_chk("R3 line status code", 3'd2, 8'h06);
        rd_chk("R6 other source read keeps transmit", 3'd2, 8'h06);
        rd_chk("R5 line status read value", 3'd5, 8'h00);
        rd_chk("R6 transmit still pending", 3'd2, 8'h02);
        rd_chk("R6 transmit cleared", 3'd2, 8'h01);
    endtask

    task automatic t_priority;
        set_lines(4'b0001);
        pulse(3);
        pulse(2);
        pulse(1);
        pulse(0);
        rd_chk("R4 line status first", 3'd2, 8'h06);
        rd_chk("R5 line status read", 3'd5, 8'h00);
        rd_chk("R4 received data second", 3'd2, 8'h04);
        rd_chk("R5 data read", 3'd0, 8'h00);
        rd_chk("R5 data read clears timeout too", 3'd2, 8'h02);
        rd_chk("R3 modem status code", 3'd2, 8'h00);
        rd_chk("R7 modem status value", 3'd6, 8'h11);
        rd_chk("R7 modem read clears", 3'd2, 8'h01);
        pulse(2);
        rd_chk("R3 timeout code", 3'd2, 8'h0C);
        pulse(1);
        rd_chk("R4 data before timeout", 3'd2, 8'h04);
        rd_chk("R5 data read", 3'd0, 8'h00);
        rd_chk("R5 both receive flags clear", 3'd2, 8'h01);
    endtask

    task automatic t_deltas;
        set_lines(4'b0101);
        rd_chk("R8 line 2 rise ignored", 3'd6, 8'h50);
        rd_chk("R8 line 2 rise no interrupt", 3'd2, 8'h01);
        set_lines(4'b0001);
        rd_chk("R8 line 2 fall flagged", 3'd6, 8'h14);
        rd_chk("R7 flags cleared", 3'd6, 8'h10);
        set_lines(4'b1001);
        rd_chk("R8 line 3 rise flagged", 3'd6, 8'h98);
        set_lines(4'b0001);
        rd_chk("R8 line 3 fall flagged", 3'd6, 8'h18);
        set_lines(4'b0000);
        rd_chk("R8 line 0 fall flagged", 3'd6, 8'h01);
        set_lines(4'b0010);
        rd_chk("R8 line 1 rise flagged", 3'd6, 8'h22);
        set_lines(4'b0000);
        rd_chk("R8 line 1 fall flagged", 3'd6, 8'h02);
        rd_chk("R7 all clear", 3'd2, 8'h01);
    endtask

    task automatic t_route;
        pulse(3);
        chk("R9 one cycle latency", {6'd0, int_n, nmi_n}, 8'h03);
        @(negedge clk);
        chk("R9 both routes open", {6'd0, int_n, nmi_n}, 8'h00);
        reg_wr(3'd4, 8'h04);
        @(negedge clk);
        chk("R9 maskable blocked", {6'd0, int_n, nmi_n}, 8'h02);
        reg_wr(3'd4, 8'h08);
        @(negedge clk);
        chk("R9 non-maskable blocked", {6'd0, int_n, nmi_n}, 8'h01);
        reg_wr(3'd4, 8'h0C);
        @(negedge clk);
        chk("R9 both blocked", {6'd0, int_n, nmi_n}, 8'h03);
        reg_wr(3'd4, 8'h13);
        @(negedge clk);
        chk("R10 spare bits no effect", {6'd0, int_n, nmi_n}, 8'h00);
        rd_chk("R10 modem control readback", 3'd4, 8'h13);
        reg_wr(3'd4, 8'hFF);
        rd_chk("R10 modem control width", 3'd4, 8'h1F);
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd0, 8'h00);
        @(negedge clk);
        chk("R9 outputs release", {6'd0, int_n, nmi_n}, 8'h03);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scratch();
        t_enable();
        t_tx_clear();
        t_priority();
        t_deltas();
        t_route();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule